// File: doc/BRIEF.md
# Input change interrupt detector

This block raises an interrupt request when a pin that is configured as an input no longer matches the level recorded for it in a stored snapshot. The snapshot is the value that software last fetched from the input port register. Each read pulse for that register re-captures the current pin levels. A pending request therefore clears either when software reads the port or when the pin goes back to its recorded level. No edge is ever latched.

The pins arrive already synchronised to `clk`. A direction mask marks which bits are inputs. The request leaves the block in two forms: an active-high pull-down enable, which drives an open-drain pad, and the equivalent active-low level. The snapshot itself is also output, so the register-read path can return it. Bus decoding, polarity inversion and the pad cells sit outside this block.

Top module: `pin_change_irq`

## Requirements
- R1: While `rst_n` is low, and until the snapshot has first been loaded, `irq_pd_en` is 0 and `snap_q` is all zeros. Within three rising edges after `rst_n` goes high, the snapshot loads the levels present on `pin_lvl`.
- R2: Once loaded, `irq_pd_en` is 1 exactly when at least one bit i has `dir_in[i]`=1 (1 = input) and `pin_lvl[i]` differs from `snap_q[i]`.
- R3: A bit with `dir_in[i]`=0 (output) never causes `irq_pd_en`, whatever its pin level.
- R4: When every mismatching input pin returns to its snapshot level, `irq_pd_en` falls in the same cycle, with no clock edge needed.
- R5: A rising edge with `snap_rd`=1 loads `pin_lvl` into `snap_q`. After that edge, the request stays clear for as long as the pins keep the values they had at that edge.
- R6: A pin change presented in the same cycle as `snap_rd` is captured into the snapshot and leaves no pending request.
- R7: Without `snap_rd`, `snap_q` holds its value regardless of changes on `pin_lvl` or `dir_in`.
- R8: Switching a bit from output to input while its pin level differs from its snapshot bit asserts `irq_pd_en` in that same cycle.
- R9: `irq_n` is always the inverse of `irq_pd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_lvl | input | WIDTH | Synchronised pin levels |
| dir_in | input | WIDTH | Direction mask, 1 = input, 0 = output |
| snap_rd | input | 1 | Read pulse of the input port register |
| snap_q | output | WIDTH | Stored snapshot of the pin levels |
| irq_pd_en | output | 1 | Open-drain pull-down enable, 1 = request active |
| irq_n | output | 1 | Active-low request level |

## Verification
The bench builds the block with WIDTH=4. At that width, every combination of snapshot, pin levels and direction mask (4096 in all) can be swept exhaustively. Each combination is compared against a mismatch OR computed arithmetically in the bench, which covers the masking, the release on return and the direction-change cases in full. Directed sequences then cover the read capture, a change that coincides with a read, and snapshot retention while the pins toggle.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int unsigned CIRQ_DEF_WIDTH = 8;
  localparam int unsigned CIRQ_SYNC_STAGES = 2;
endpackage

// File: rtl/cirq_rst_sync.sv
module cirq_rst_sync #(
  parameter int unsigned STAGES = cirq_pkg::CIRQ_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cirq_snapshot.sv
module cirq_snapshot #(
  parameter int unsigned WIDTH = cirq_pkg::CIRQ_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic             snap_rd,
  output logic [WIDTH-1:0] snap_q,
  output logic             valid_q
);
  logic             load_en;
  logic [WIDTH-1:0] snap_d;
  logic             valid_d;

  always_comb begin
    load_en = snap_rd | ~valid_q;
    snap_d  = pin_lvl;
    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load_en) snap_q <= snap_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/cirq_compare.sv
module cirq_compare #(
  parameter int unsigned WIDTH = cirq_pkg::CIRQ_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic [WIDTH-1:0] snap_q,
  input  logic [WIDTH-1:0] dir_in,
  output logic [WIDTH-1:0] mism
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign mism[i] = dir_in[i] & (pin_lvl[i] ^ snap_q[i]);
  end
endmodule

// File: rtl/cirq_reduce.sv
module cirq_reduce #(
  parameter int unsigned WIDTH = cirq_pkg::CIRQ_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] mism,
  input  logic             valid,
  output logic             irq_pd_en,
  output logic             irq_n
);
  logic any_mism;

  always_comb begin
    any_mism  = |mism;
    irq_pd_en = valid & any_mism;
    irq_n     = ~irq_pd_en;
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned WIDTH = cirq_pkg::CIRQ_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic [WIDTH-1:0] dir_in,
  input  logic             snap_rd,
  output logic [WIDTH-1:0] snap_q,
  output logic             irq_pd_en,
  output logic             irq_n
);
  logic             rst_sync_n;
  logic             snap_valid;
  logic [WIDTH-1:0] mism;

  cirq_rst_sync #(.STAGES(cirq_pkg::CIRQ_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cirq_snapshot #(.WIDTH(WIDTH)) u_snap (
    .clk(clk), .rst_n(rst_sync_n), .pin_lvl(pin_lvl), .snap_rd(snap_rd),
    .snap_q(snap_q), .valid_q(snap_valid)
  );

  cirq_compare #(.WIDTH(WIDTH)) u_cmp (
    .pin_lvl(pin_lvl), .snap_q(snap_q), .dir_in(dir_in), .mism(mism)
  );

  cirq_reduce #(.WIDTH(WIDTH)) u_red (
    .mism(mism), .valid(snap_valid), .irq_pd_en(irq_pd_en), .irq_n(irq_n)
  );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             snap_valid,
  input logic [WIDTH-1:0] pin_lvl,
  input logic [WIDTH-1:0] dir_in,
  input logic             snap_rd,
  input logic [WIDTH-1:0] snap_q,
  input logic             irq_pd_en,
  input logic             irq_n
);
  AST_UNLOADED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_valid |-> !irq_pd_en); // R1

  AST_OUTPUTS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in == '0) |-> !irq_pd_en); // R3

  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl == snap_q) |-> !irq_pd_en); // R4

  AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && snap_rd) |=> (snap_q == $past(pin_lvl))); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && snap_rd) |=> ((pin_lvl != $past(pin_lvl)) || !irq_pd_en)); // R6

  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && snap_valid && !snap_rd) |=> $stable(snap_q)); // R7

  AST_LEVEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n != irq_pd_en); // R9
endmodule

bind pin_change_irq pin_change_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .snap_valid(snap_valid),
  .pin_lvl(pin_lvl), .dir_in(dir_in), .snap_rd(snap_rd), .snap_q(snap_q),
  .irq_pd_en(irq_pd_en), .irq_n(irq_n)
);

// File: tb/sim_pin_change_irq.sv
`timescale 1ns/1ps
module sim_pin_change_irq;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] pin_lvl;
  logic [W-1:0] dir_in;
  logic         snap_rd;
  logic [W-1:0] snap_q;
  logic         irq_pd_en;
  logic         irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_change_irq #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir_in(dir_in),
    .snap_rd(snap_rd), .snap_q(snap_q), .irq_pd_en(irq_pd_en), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_irq(input int s, input int p, input int d);
    return (((p ^ s) & d) != 0) ? 1 : 0;
  endfunction

  task automatic load_snap(input int s);
    @(negedge clk);
    pin_lvl = W'(s);
    snap_rd = 1'b1;
    @(negedge clk);
    snap_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; pin_lvl = 4'hA; dir_in = '1; snap_rd = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq in reset", int'(irq_pd_en), 0);
    chk("R1 snap in reset", int'(snap_q), 0);
    chk("R9 irq_n in reset", int'(irq_n), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 snap loaded", int'(snap_q), 'hA);
    chk("R1 no irq after load", int'(irq_pd_en), 0);

    // R2 R3 R4 R8 R9: exhaustive sweep
    for (int s = 0; s < N; s++) begin
      load_snap(s);
      for (int d = 0; d < N; d++) begin
        for (int p = 0; p < N; p++) begin
          pin_lvl = W'(p); dir_in = W'(d);
          #1;
          chk("R2 masked mismatch", int'(irq_pd_en), exp_irq(s, p, d));
          chk("R9 inverse level", int'(irq_n), 1 - exp_irq(s, p, d));
        end
        // R4: return to the snapshot level clears without a clock
        pin_lvl = W'(s);
        #1;
        chk("R4 return clears", int'(irq_pd_en), 0);
      end
      chk("R7 snapshot held over sweep", int'(snap_q), s);
    end

    // R3: output bits toggling
    load_snap(0);
    dir_in = 4'b0000; pin_lvl = 4'hF; #1;
    chk("R3 outputs ignored", int'(irq_pd_en), 0);
    // R8: direction flip with a mismatching pin
    dir_in = 4'b0100; #1;
    chk("R8 dir flip asserts", int'(irq_pd_en), 1);

    // R5: read clears a pending request
    @(negedge clk);
    dir_in = '1; pin_lvl = 4'h5; #1;
    chk("R5 pending before read", int'(irq_pd_en), 1);
    snap_rd = 1'b1;
    @(negedge clk); snap_rd = 1'b0; #1;
    chk("R5 snapshot captured", int'(snap_q), 'h5);
    chk("R5 cleared after read", int'(irq_pd_en), 0);

    // R6: change coincident with read
    @(negedge clk);
    pin_lvl = 4'hC; snap_rd = 1'b1;
    @(negedge clk); snap_rd = 1'b0; #1;
    chk("R6 coincident change captured", int'(snap_q), 'hC);
    chk("R6 no request left", int'(irq_pd_en), 0);

    // R7: no read, pins and dir toggle across edges
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pin_lvl = W'(k * 3); dir_in = W'(k);
    end
    #1;
    chk("R7 snapshot retained", int'(snap_q), 'hC);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule